// File: doc/BRIEF.md
# Predicate Register File Unit

This block holds the one-bit predicates that decide whether each instruction of a three-slot bundle is allowed to commit. Every slot presents a 6-bit qualifying-predicate index. The block returns that predicate's current value as the slot's commit enable. It also uses that value to mask the slot's register-write request, so an instruction whose predicate is false leaves no trace.

Predicates are written in two ways. The first is per-slot compare results: a compare names two destinations, puts its condition result in the first and the inverse in the second, and does so only when its own qualifying predicate is true. The second is a bulk load that replaces the whole file from a 64-bit word. Predicate 0 is hardwired true. Reads are combinational from the stored state. Writes become visible after the next rising clock edge.

Top module: `pred_file_unit`

## Requirements
- R1: After reset, predicate 0 reads 1 and predicates 1 to 63 read 0.
- R2: Predicate 0 always reads 1. A compare or bulk write that targets it, including a bulk word whose bit 0 is 0, leaves it at 1.
- R3: A compare enabled on a slot writes its result to destination A and the inverse of the result to destination B. Both values are readable after the next rising edge. If A and B name the same predicate, the value for A is kept.
- R4: When a slot's qualifying predicate is 0, that slot's compare changes no predicate and its `reg_we_gated` bit is 0. When the predicate is 1, `reg_we_gated` follows `reg_we_req`.
- R5: Each of the three slots reads independently and combinationally. `commit_en[s]` equals the predicate whose index sits in bits `[6s+5:6s]` of `qp_idx`.
- R6: When two slots write the same predicate in one cycle, the value from the highest-numbered slot is kept.
- R7: A bulk load copies bit i of `bulk_val` into predicate i for every i from 1 to 63. In a cycle with a bulk load, all compare writes are dropped.
- R8: A compare's qualifying predicate is read from the state before the edge. A predicate set by another slot in the same cycle does not enable it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| qp_idx | input | 18 | Qualifying-predicate index, 6 bits per slot, slot 0 lowest |
| commit_en | output | 3 | Per-slot value of the selected qualifying predicate |
| reg_we_req | input | 3 | Per-slot register-write request |
| reg_we_gated | output | 3 | Write request masked by the slot's commit enable |
| cmp_we | input | 3 | Per-slot compare-result write request |
| cmp_res | input | 3 | Per-slot compare condition result |
| cmp_dst_a | input | 18 | Per-slot index that receives the result |
| cmp_dst_b | input | 18 | Per-slot index that receives the inverse |
| bulk_we | input | 1 | Load the whole file this cycle |
| bulk_val | input | 64 | Word loaded by a bulk write |

## Verification
The bench goes after collisions. Two slots hit one predicate, and a design with the slot priority reversed would keep slot 0's value. A compare uses both its destinations on the same index, and a design that writes B last would store the inverse. A bulk load lands together with a compare, and a design that lets the compare through would corrupt the loaded word. The bench also qualifies a slot on a predicate that another slot sets in the same cycle; a design with a write bypass would let that compare fire. Writes aimed at predicate 0 are checked too, since they would expose a design that stores that bit.

// File: rtl/pred_file_unit.sv
module pred_file_unit #(
  parameter  int NUM_PRED  = 64,
  parameter  int NUM_SLOTS = 3,
  localparam int IDX_W     = $clog2(NUM_PRED)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS*IDX_W-1:0] qp_idx,
  output logic [NUM_SLOTS-1:0]       commit_en,
  input  logic [NUM_SLOTS-1:0]       reg_we_req,
  output logic [NUM_SLOTS-1:0]       reg_we_gated,
  input  logic [NUM_SLOTS-1:0]       cmp_we,
  input  logic [NUM_SLOTS-1:0]       cmp_res,
  input  logic [NUM_SLOTS*IDX_W-1:0] cmp_dst_a,
  input  logic [NUM_SLOTS*IDX_W-1:0] cmp_dst_b,
  input  logic                       bulk_we,
  input  logic [NUM_PRED-1:0]        bulk_val
);

  localparam logic [NUM_PRED-1:0] RST_VAL = {{(NUM_PRED-1){1'b0}}, 1'b1};

  logic [NUM_PRED-1:0] pr_q, pr_d;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_rd
    logic [IDX_W-1:0] sel;
    assign sel          = qp_idx[s*IDX_W +: IDX_W];
    assign commit_en[s] = (sel == '0) | pr_q[sel];
  end

  assign reg_we_gated = reg_we_req & commit_en;

  always_comb begin
    pr_d = pr_q;
    if (bulk_we) begin
      pr_d = bulk_val;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cmp_we[s] && commit_en[s]) begin
          pr_d[cmp_dst_b[s*IDX_W +: IDX_W]] = ~cmp_res[s];
          pr_d[cmp_dst_a[s*IDX_W +: IDX_W]] =  cmp_res[s];
        end
      end
    end
    pr_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pr_q <= RST_VAL;
    else        pr_q <= pr_d;
  end

endmodule

module pred_file_unit_chk #(
  parameter  int NUM_PRED  = 64,
  parameter  int NUM_SLOTS = 3,
  localparam int IDX_W     = $clog2(NUM_PRED)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SLOTS*IDX_W-1:0] qp_idx,
  input logic [NUM_SLOTS-1:0]       commit_en,
  input logic [NUM_SLOTS-1:0]       cmp_we,
  input logic [NUM_SLOTS-1:0]       cmp_res,
  input logic [NUM_SLOTS*IDX_W-1:0] cmp_dst_a,
  input logic                       bulk_we,
  input logic [NUM_PRED-1:0]        bulk_val,
  input logic [NUM_PRED-1:0]        pr_q
);

  logic [IDX_W-1:0] top_a;
  assign top_a = cmp_dst_a[(NUM_SLOTS-1)*IDX_W +: IDX_W];

  AST_P0_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (qp_idx[IDX_W-1:0] == '0) |-> commit_en[0]); // R2

  AST_BULK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_we |=> (pr_q[NUM_PRED-1:1] == $past(bulk_val[NUM_PRED-1:1]))); // R7

  AST_TOP_SLOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we[NUM_SLOTS-1] && commit_en[NUM_SLOTS-1] && !bulk_we && top_a != '0)
    |=> (pr_q[$past(top_a)] == $past(cmp_res[NUM_SLOTS-1]))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bulk_we && ((cmp_we & commit_en) == '0)) |=> $stable(pr_q)); // R4

endmodule

bind pred_file_unit pred_file_unit_chk #(.NUM_PRED(NUM_PRED), .NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/pred_file_unit_tb_top.sv
`timescale 1ns/1ps
module pred_file_unit_tb_top;
  localparam int NP = 64, NS = 3, IW = 6;

  logic clk = 0, rst_n = 0;
  logic [NS*IW-1:0] qp_idx = '0, cmp_dst_a = '0, cmp_dst_b = '0;
  logic [NS-1:0] commit_en, reg_we_req = '0, reg_we_gated, cmp_we = '0, cmp_res = '0;
  logic bulk_we = 0;
  logic [NP-1:0] bulk_val = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pred_file_unit dut_i (.*);

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clear_in;
    qp_idx = '0; cmp_dst_a = '0; cmp_dst_b = '0;
    cmp_we = '0; cmp_res = '0; reg_we_req = '0; bulk_we = 0; bulk_val = '0;
  endtask

  task automatic set_cmp(input int s, input int qp, input int a, input int b, input logic r);
    cmp_we[s] = 1'b1; cmp_res[s] = r;
    qp_idx[s*IW +: IW] = 6'(qp);
    cmp_dst_a[s*IW +: IW] = 6'(a);
    cmp_dst_b[s*IW +: IW] = 6'(b);
  endtask

  task automatic tick;
    @(negedge clk);
    clear_in();
  endtask

  task automatic rd(input string req, input int idx, input logic exp);
    qp_idx[IW-1:0] = 6'(idx);
    #1;
    chk(req, commit_en[0], exp, $sformatf("p%0d", idx));
  endtask

  task automatic t_reset;
    @(negedge clk);
    rd("R1", 0, 1'b1); rd("R1", 5, 1'b0); rd("R1", 63, 1'b0);
    qp_idx = {6'd33, 6'd0, 6'd1}; #1;
    chk("R1", commit_en[1], 1'b1, "slot1 p0");
    chk("R1", commit_en[2], 1'b0, "slot2 p33");
    clear_in();
  endtask

  task automatic t_cmp_pair;
    @(negedge clk);
    set_cmp(0, 0, 10, 11, 1'b1); tick();
    rd("R3", 10, 1'b1); rd("R3", 11, 1'b0);
    set_cmp(1, 0, 12, 13, 1'b0); tick();
    rd("R3", 12, 1'b0); rd("R3", 13, 1'b1);
    set_cmp(0, 0, 14, 14, 1'b1); tick();
    rd("R3", 14, 1'b1);
  endtask

  task automatic t_gate;
    @(negedge clk);
    set_cmp(1, 11, 20, 21, 1'b1);
    set_cmp(2, 11, 22, 23, 1'b0); tick();
    rd("R4", 20, 1'b0); rd("R4", 21, 1'b0); rd("R4", 23, 1'b0);
    reg_we_req = 3'b111; qp_idx = {6'd0, 6'd10, 6'd11}; #1;
    chk("R4", reg_we_gated[0], 1'b0, "gated we slot0 qp false");
    chk("R4", reg_we_gated[1], 1'b1, "gated we slot1 qp true");
    chk("R4", reg_we_gated[2], 1'b1, "gated we slot2 qp p0");
    clear_in();
  endtask

  task automatic t_p0;
    @(negedge clk);
    set_cmp(0, 0, 0, 30, 1'b0); tick();
    rd("R2", 0, 1'b1); rd("R2", 30, 1'b1);
    set_cmp(1, 0, 31, 0, 1'b1); tick();
    rd("R2", 0, 1'b1); rd("R2", 31, 1'b1);
  endtask

  task automatic t_prio;
    @(negedge clk);
    set_cmp(0, 0, 40, 41, 1'b1);
    set_cmp(2, 0, 40, 42, 1'b0); tick();
    rd("R6", 40, 1'b0); rd("R6", 41, 1'b0); rd("R6", 42, 1'b1);
    set_cmp(0, 0, 45, 46, 1'b1);
    set_cmp(1, 0, 46, 47, 1'b1); tick();
    rd("R6", 45, 1'b1); rd("R6", 46, 1'b1); rd("R6", 47, 1'b0);
  endtask

  task automatic t_no_bypass;
    @(negedge clk);
    set_cmp(0, 0, 50, 51, 1'b1);
    set_cmp(2, 50, 52, 53, 1'b1); #1;
    chk("R8", commit_en[2], 1'b0, "slot2 qp p50 before edge");
    tick();
    rd("R8", 50, 1'b1); rd("R8", 52, 1'b0); rd("R8", 53, 1'b0);
  endtask

  task automatic t_bulk;
    logic [NP-1:0] w;
    @(negedge clk);
    bulk_we = 1; bulk_val = 64'h1 << 16;
    set_cmp(0, 0, 16, 17, 1'b0);
    set_cmp(1, 0, 18, 19, 1'b1); tick();
    rd("R7", 16, 1'b1); rd("R7", 17, 1'b0); rd("R7", 18, 1'b0);
    rd("R7", 10, 1'b0); rd("R2", 0, 1'b1);
    w = 64'hC3A5_0000_F00F_5A5A;
    bulk_we = 1; bulk_val = w; tick();
    rd("R2", 0, 1'b1);
    for (int i = 1; i < NP; i += 3) rd("R7", i, w[i]);
    rd("R7", 63, w[63]);
  endtask

  task automatic t_ports;
    @(negedge clk);
    qp_idx = {6'd4, 6'd61, 6'd63}; #1;
    chk("R5", commit_en[0], 1'b1, "slot0 p63");
    chk("R5", commit_en[1], 1'b0, "slot1 p61");
    chk("R5", commit_en[2], 1'b1, "slot2 p4");
    qp_idx = {6'd5, 6'd62, 6'd2}; #1;
    chk("R5", commit_en[0], 1'b0, "slot0 p2");
    chk("R5", commit_en[1], 1'b1, "slot1 p62");
    chk("R5", commit_en[2], 1'b0, "slot2 p5");
    clear_in();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cmp_pair();
    t_gate();
    t_p0();
    t_prio();
    t_no_bypass();
    t_bulk();
    t_ports();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule